// File: doc/BRIEF.md
# Strobe-Relative Setup/Hold Window Checker

This block watches a data bus and a strobe signal, sampling both on the rising edge of a sampling clock. It finds the active strobe edge. An edge-polarity input chooses whether the rising or the falling edge of the strobe counts as active. Around each active edge it checks two cycle-counted windows. The setup window looks back over the samples that lead up to the edge. The hold window runs forward from the edge. Both windows ask one question: did the data bus change between consecutive samples?

For each violation the block emits a one-cycle error pulse, one output for setup and one for hold. Next to each pulse output it keeps a sticky flag and a saturating violation counter. The block is meant for use on a chip as a cheap observer of an interface whose data must settle around a sampled strobe. The window lengths are elaboration parameters.

Top module: `strobe_window_check`

## Requirements
- R1: With `edge_fall`=1 the falling strobe edge is active. With `edge_fall`=0 the rising edge is active. An edge is detected when the level `~(strobe ^ edge_fall)` goes from 1 in one sample to 0 in the next. So a change of `edge_fall` alone is also an edge: 1 to 0 while the strobe is high, or 0 to 1 while the strobe is low.
- R2: `setup_err` pulses when an active edge is sampled and data differed between consecutive samples in any of the SETUP_CYC comparisons that end at the edge sample. With the default of 2, these are the edge sample against the one before it, and the one before against the one before that.
- R3: The hold window compares the edge sample with the sample before it, then each of the next HOLD_CYC-1 samples with its predecessor. A value of 0 behaves like 1. `hold_err` pulses on the first mismatch, and that window then closes.
- R4: An active edge that arrives while a hold window is open restarts the window at its full length.
- R5: Both error outputs are registered. Each is high for the one cycle that follows the clock edge which sampled the offending inputs.
- R6: `setup_seen` and `hold_seen` go high with the first pulse of their kind and stay high until reset.
- R7: `setup_cnt` and `hold_cnt` add one per pulse and hold at their maximum value, 255 for the default CNT_W of 8.
- R8: While reset is asserted, all outputs are 0. The first sample after reset only primes the history, so it reports no edge and no change.
- R9: A data change outside any setup or hold window raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Strobe being watched |
| edge_fall | input | 1 | 1: falling edge active, 0: rising edge active |
| data | input | DATA_W | Data bus being watched |
| setup_err | output | 1 | One-cycle setup violation pulse |
| hold_err | output | 1 | One-cycle hold violation pulse |
| setup_seen | output | 1 | Sticky setup violation flag |
| hold_seen | output | 1 | Sticky hold violation flag |
| setup_cnt | output | CNT_W | Saturating setup violation count |
| hold_cnt | output | CNT_W | Saturating hold violation count |

## Verification
Each error pulse is due exactly one clock after the rising edge that samples the edge or mismatch cycle. The flags and counters move on that same edge. The bench drives inputs on the falling edge. It reads every output on the next falling edge, where the result of the sample in between has to be visible, so every vector row carries the pulse values expected for its own inputs. The overlap, polarity-swap and out-of-window rows are placed so that a window one cycle too short or too long changes a pulse in a named row.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
  // Per-sample observation handed from the sampler to the window checkers.
  typedef struct packed {
    logic act_edge;
    logic changed;
  } ssh_obs_t;
endpackage

// File: rtl/ssh_sampler.sv
module ssh_sampler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              edge_fall,
  input  logic [DATA_W-1:0] data,
  output ssh_pkg::ssh_obs_t obs,
  output logic              primed
);
  logic              lvl_now;
  logic              lvl_q, lvl_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              primed_n;

  // Level is 1 before an active edge and 0 after, for either polarity.
  assign lvl_now = ~(strobe ^ edge_fall);

  always_comb begin
    lvl_n    = lvl_now;
    data_n   = data;
    primed_n = 1'b1;
    obs.act_edge = primed & lvl_q & ~lvl_now;
    obs.changed  = primed & (data != data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      data_q <= '0;
      primed <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      data_q <= data_n;
      primed <= primed_n;
    end
  end
endmodule

// File: rtl/ssh_setup_win.sv
module ssh_setup_win #(
  parameter int SETUP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssh_pkg::ssh_obs_t obs,
  output logic              err
);
  localparam int HIST_W = (SETUP_CYC > 1) ? SETUP_CYC - 1 : 1;

  logic err_n;
  logic hit;

  generate
    if (SETUP_CYC == 0) begin : g_off
      assign hit = 1'b0;
    end else if (SETUP_CYC == 1) begin : g_edge_only
      assign hit = obs.changed;
    end else begin : g_hist
      logic [HIST_W-1:0] hist_q, hist_n;
      always_comb begin
        hist_n[0] = obs.changed;
        for (int i = 1; i < HIST_W; i++) hist_n[i] = hist_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_n;
      end
      assign hit = obs.changed | (|hist_q);
    end
  endgenerate

  assign err_n = obs.act_edge & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_n;
  end
endmodule

// File: rtl/ssh_hold_win.sv
module ssh_hold_win #(
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssh_pkg::ssh_obs_t obs,
  output logic              err
);
  localparam int REM_MAX = (HOLD_CYC > 1) ? HOLD_CYC - 1 : 0;
  localparam int REM_W   = (REM_MAX > 0) ? $clog2(REM_MAX + 1) : 1;

  logic [REM_W-1:0] rem_q, rem_n;
  logic             err_n;

  always_comb begin
    err_n = 1'b0;
    rem_n = rem_q;
    if (obs.act_edge) begin
      if (obs.changed) begin
        err_n = 1'b1;
        rem_n = '0;
      end else begin
        rem_n = REM_W'(REM_MAX);
      end
    end else if (rem_q != '0) begin
      if (obs.changed) begin
        err_n = 1'b1;
        rem_n = '0;
      end else begin
        rem_n = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      err   <= 1'b0;
    end else begin
      rem_q <= rem_n;
      err   <= err_n;
    end
  end

  // R3: the window never runs longer than the configured length
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= REM_W'(REM_MAX));
  // R4: a clean edge always reopens the window at full length
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (obs.act_edge && !obs.changed) |=> (rem_q == REM_W'(REM_MAX)));
endmodule

// File: rtl/ssh_err_tally.sv
module ssh_err_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  output logic             seen,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             seen_n;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  assign cnt_en = pulse & (cnt != CNT_MAX);

  always_comb begin
    seen_n = seen | pulse;
    cnt_n  = cnt_en ? cnt + 1'b1 : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      cnt  <= '0;
    end else begin
      seen <= seen_n;
      cnt  <= cnt_n;
    end
  end

  // R6: sticky flag never drops without reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> seen);
  // R6: a nonzero count implies the flag is up
  a_r6_flag_with_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> seen);
  // R7: saturated counter stays put
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/strobe_window_check.sv
module strobe_window_check #(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 3,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              edge_fall,
  input  logic [DATA_W-1:0] data,
  output logic              setup_err,
  output logic              hold_err,
  output logic              setup_seen,
  output logic              hold_seen,
  output logic [CNT_W-1:0]  setup_cnt,
  output logic [CNT_W-1:0]  hold_cnt
);
  ssh_pkg::ssh_obs_t obs_w;
  logic              primed_w;

  ssh_sampler #(.DATA_W(DATA_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .edge_fall(edge_fall),
    .data(data), .obs(obs_w), .primed(primed_w)
  );

  ssh_setup_win #(.SETUP_CYC(SETUP_CYC)) u_setup (
    .clk(clk), .rst_n(rst_n), .obs(obs_w), .err(setup_err)
  );

  ssh_hold_win #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .obs(obs_w), .err(hold_err)
  );

  ssh_err_tally #(.CNT_W(CNT_W)) u_setup_tally (
    .clk(clk), .rst_n(rst_n), .pulse(setup_err), .seen(setup_seen), .cnt(setup_cnt)
  );

  ssh_err_tally #(.CNT_W(CNT_W)) u_hold_tally (
    .clk(clk), .rst_n(rst_n), .pulse(hold_err), .seen(hold_seen), .cnt(hold_cnt)
  );

  // R2: a setup pulse only follows a sampled active edge
  a_r2_setup_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err |-> $past(obs_w.act_edge));
  // R5: active edges cannot be adjacent, so a setup pulse lasts one cycle
  a_r5_setup_single: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err |=> !setup_err);
  // R8: the priming sample reports nothing
  a_r8_quiet_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_w |=> (!setup_err && !hold_err));
endmodule

// File: tb/sim_strobe_window_check.sv
module sim_strobe_window_check;
  localparam int CLK_PER = 10;
  localparam int NV = 33;

  logic       clk;
  logic       rst_n;
  logic       strobe;
  logic       edge_fall;
  logic [7:0] data;
  logic       setup_err, hold_err, setup_seen, hold_seen;
  logic [7:0] setup_cnt, hold_cnt;

  int total;
  int bad;

  strobe_window_check u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .edge_fall(edge_fall), .data(data),
    .setup_err(setup_err), .hold_err(hold_err), .setup_seen(setup_seen),
    .hold_seen(hold_seen), .setup_cnt(setup_cnt), .hold_cnt(hold_cnt)
  );

  // Row layout: {strobe, edge_fall, data[7:0], exp_setup_err, exp_hold_err}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // 0 priming sample (R8)
    {1'b1, 1'b1, 8'h00, 1'b0, 1'b0},  // 1 rising strobe, inactive (R1)
    {1'b1, 1'b1, 8'h00, 1'b0, 1'b0},  // 2
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // 3 falling edge, clean
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // 4 hold window
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // 5 hold window end
    {1'b1, 1'b1, 8'h05, 1'b0, 1'b0},  // 6 change, no window (R9)
    {1'b0, 1'b1, 8'h05, 1'b1, 1'b0},  // 7 edge, change one sample earlier (R2)
    {1'b0, 1'b1, 8'h05, 1'b0, 1'b0},  // 8
    {1'b0, 1'b1, 8'h06, 1'b0, 1'b1},  // 9 change in last hold sample (R3)
    {1'b1, 1'b1, 8'h06, 1'b0, 1'b0},  // 10
    {1'b1, 1'b1, 8'h06, 1'b0, 1'b0},  // 11
    {1'b0, 1'b1, 8'h07, 1'b1, 1'b1},  // 12 change at edge sample (R2, R3)
    {1'b0, 1'b1, 8'h07, 1'b0, 1'b0},  // 13 window closed after error (R3)
    {1'b0, 1'b1, 8'h08, 1'b0, 1'b0},  // 14 change, no window (R9)
    {1'b0, 1'b0, 8'h08, 1'b0, 1'b0},  // 15 switch to rising mode, no edge
    {1'b1, 1'b0, 8'h08, 1'b0, 1'b0},  // 16 rising edge; change 2 back is outside (R2)
    {1'b1, 1'b0, 8'h08, 1'b0, 1'b0},  // 17
    {1'b0, 1'b0, 8'h08, 1'b0, 1'b0},  // 18 falling strobe, inactive (R1)
    {1'b1, 1'b0, 8'h08, 1'b0, 1'b0},  // 19 rising edge
    {1'b1, 1'b0, 8'h09, 1'b0, 1'b1},  // 20 hold break (R3)
    {1'b0, 1'b0, 8'h09, 1'b0, 1'b0},  // 21
    {1'b1, 1'b0, 8'h09, 1'b0, 1'b0},  // 22 edge A
    {1'b0, 1'b0, 8'h09, 1'b0, 1'b0},  // 23
    {1'b1, 1'b0, 8'h09, 1'b0, 1'b0},  // 24 edge B inside window A (R4)
    {1'b1, 1'b0, 8'h09, 1'b0, 1'b0},  // 25
    {1'b1, 1'b0, 8'h0A, 1'b0, 1'b1},  // 26 only inside restarted window (R4)
    {1'b1, 1'b0, 8'h0A, 1'b0, 1'b0},  // 27 single-cycle pulse (R5)
    {1'b1, 1'b1, 8'h0B, 1'b0, 1'b0},  // 28 select 0->1 with strobe high: no edge
    {1'b1, 1'b0, 8'h0B, 1'b1, 1'b0},  // 29 select 1->0 with strobe high: edge (R1)
    {1'b1, 1'b0, 8'h0B, 1'b0, 1'b0},  // 30
    {1'b1, 1'b0, 8'h0B, 1'b0, 1'b0},  // 31
    {1'b1, 1'b0, 8'h0C, 1'b0, 1'b0}   // 32 change just after window (R9)
  };

  initial begin
    clk = 1'b0;
    forever #(CLK_PER / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic f, input logic [7:0] d);
    strobe    = s;
    edge_fall = f;
    data      = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 setup_err in reset", {31'b0, setup_err}, 32'd0);
    chk("R8 hold_err in reset", {31'b0, hold_err}, 32'd0);
    chk("R8 flags in reset", {30'b0, setup_seen, hold_seen}, 32'd0);
    chk("R8 counters in reset", {16'b0, setup_cnt, hold_cnt}, 32'd0);

    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11], VEC[i][10], VEC[i][9:2]);
      @(negedge clk);
      chk($sformatf("R1/R2/R5 setup_err row %0d", i), {31'b0, setup_err}, {31'b0, VEC[i][1]});
      chk($sformatf("R1/R3/R4 hold_err row %0d", i), {31'b0, hold_err}, {31'b0, VEC[i][0]});
    end
    // R6, R7: tallies after the table
    chk("R6 setup_seen", {31'b0, setup_seen}, 32'd1);
    chk("R6 hold_seen", {31'b0, hold_seen}, 32'd1);
    chk("R7 setup_cnt", {24'b0, setup_cnt}, 32'd3);
    chk("R7 hold_cnt", {24'b0, hold_cnt}, 32'd4);

    // R7: drive well past saturation with violating rising edges
    for (int k = 0; k < 260; k++) begin
      drive(1'b0, 1'b0, 8'(2 * k));
      @(negedge clk);
      drive(1'b1, 1'b0, 8'(2 * k + 1));
      @(negedge clk);
      if (k == 0) begin
        chk("R2 setup_err on changing edge", {31'b0, setup_err}, 32'd1);
        chk("R3 hold_err on changing edge", {31'b0, hold_err}, 32'd1);
      end
    end
    chk("R7 setup_cnt saturated", {24'b0, setup_cnt}, 32'd255);
    chk("R7 hold_cnt saturated", {24'b0, hold_cnt}, 32'd255);
    chk("R6 flags held", {30'b0, setup_seen, hold_seen}, 32'd3);

    // R8: asynchronous reset mid-run clears everything
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 8'hC3);
    #1;
    chk("R8 async clear cnt", {16'b0, setup_cnt, hold_cnt}, 32'd0);
    chk("R8 async clear flags", {30'b0, setup_seen, hold_seen}, 32'd0);
    @(negedge clk);
    // R8: first sample after reset looks like a changing falling edge but only primes
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 8'h3C);
    @(negedge clk);
    chk("R8 priming sample setup_err", {31'b0, setup_err}, 32'd0);
    chk("R8 priming sample hold_err", {31'b0, hold_err}, 32'd0);
    @(negedge clk);
    chk("R8 after priming", {30'b0, setup_err, hold_err}, 32'd0);
    chk("R8 counters after priming", {16'b0, setup_cnt, hold_cnt}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule